// File: doc/BRIEF.md
# Flash Ready/Busy Status Pin Controller

This block drives one status pin and a small polled status register for an embedded flash write engine. It watches the engine's busy flag, a one-cycle completion strobe that carries the kind of operation that finished, and two suspend indications. The block also accepts a two-bit mode code through a configuration write strobe. In level mode, the pin works as a ready/busy line: it is low while an erase, a program or a lock-bit update runs, and high at all other times. In the pulse modes, the pin rests high. It drops low for a fixed number of clocks each time an enabled kind of operation completes. Erase and program completions are enabled separately.

A status register can be polled in place of the pin. It shows whether the engine is ready and latches the erase-suspended and program-suspended conditions. A configuration write that arrives while the engine is busy is held back until the engine is ready again. The active-low reset/power-down input returns everything to level mode, clears the register and cancels any pulse in progress.

Top module: `flash_sts_pin`

## Requirements
- R1: While the reset/power-down input `pd_n` is low, `sts_pin` is 1 and `stat` is 8'h80. After release, the mode is level and no pulse is pending.
- R2: In level mode (code 2'b00), after each clock edge `sts_pin` equals the inverse of `wsm_busy` sampled at that edge. The pin is therefore also high while an operation is suspended and the engine reports not busy.
- R3: A `cfg_we` sampled while `wsm_busy` is 0 loads `cfg_mode` as the new mode, effective from the next edge. The codes are: 2'b00 level, 2'b01 pulse on erase completion, 2'b10 pulse on program completion, 2'b11 pulse on both.
- R4: A completion is a `done` strobe qualified by `done_kind` (2'b00 erase, 2'b01 program, 2'b10 lock-bit). Only the kinds enabled by the current mode start a pulse. Lock-bit completions and all completions in level mode produce no pulse.
- R5: In a pulse mode, an enabled completion sampled at edge k drives `sts_pin` low from edge k for exactly PULSE_LEN clocks (default 2). The pin then returns high.
- R6: An enabled completion sampled during a pulse restarts the low count at PULSE_LEN.
- R7: After each edge, `stat[7]` is the inverse of `wsm_busy` sampled at that edge.
- R8: `stat[6]` is set when `ers_susp` is sampled high. It stays set until an edge samples `wsm_busy`=1 with `ers_susp`=0 (resume).
- R9: `stat[2]` behaves like `stat[6]`, driven by `prg_susp`. All other `stat` bits are 0.
- R10: A `cfg_we` sampled while `wsm_busy` is 1 leaves the mode unchanged until the first edge that samples `wsm_busy`=0. From the following edge the held code is in force.
- R11: In a pulse mode, `sts_pin` does not follow `wsm_busy`. It stays high while busy unless a pulse is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pd_n | input | 1 | Active-low reset/power-down, asynchronous assert |
| wsm_busy | input | 1 | Write engine running an erase, program or lock-bit update |
| done | input | 1 | One-cycle completion strobe |
| done_kind | input | 2 | Kind of completed operation: 00 erase, 01 program, 10 lock-bit |
| ers_susp | input | 1 | Erase suspended indication |
| prg_susp | input | 1 | Program suspended indication |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code written by `cfg_we` |
| sts_pin | output | 1 | Status pin |
| stat | output | 8 | Polled status register |

## Verification
The bench checks corner cases where a faulty design behaves visibly differently:
- A completion that arrives during a pulse must extend the pulse. A design that ignores the retrigger would go high one pulse-length too early.
- A lock-bit completion, or a completion of a kind the mode does not enable, must produce no pulse. A design that pulses on every completion would show a spurious low.
- A mode write made while busy must keep the old mode until the engine is ready. A design that applies it at once would pulse on the wrong kind of completion.
- The suspend flags must survive idle cycles and clear only on resume. Reset in the middle of a pulse must bring the pin straight back high and restore level tracking.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;

    typedef enum logic [1:0] {
        MODE_LEVEL = 2'b00,
        MODE_ERASE = 2'b01,
        MODE_PROG  = 2'b10,
        MODE_BOTH  = 2'b11
    } sts_mode_e;

    typedef enum logic [1:0] {
        OP_ERASE = 2'b00,
        OP_PROG  = 2'b01,
        OP_LOCK  = 2'b10,
        OP_RSVD  = 2'b11
    } op_kind_e;

    localparam int unsigned STAT_W       = 8;
    localparam int unsigned STAT_RDY_BIT = 7;
    localparam int unsigned STAT_ES_BIT  = 6;
    localparam int unsigned STAT_PS_BIT  = 2;

    function automatic logic kind_enabled(sts_mode_e mode, op_kind_e kind);
        logic en;
        unique case (kind)
            OP_ERASE: en = mode[0];
            OP_PROG:  en = mode[1];
            default:  en = 1'b0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/flash_sts_cfg.sv
module flash_sts_cfg
    import flash_sts_pkg::*;
(
    input  logic      clk,
    input  logic      pd_n,
    input  logic      busy,
    input  logic      cfg_we,
    input  sts_mode_e cfg_mode,
    output sts_mode_e mode
);

    typedef struct packed {
        sts_mode_e mode;
        logic      pend;
        sts_mode_e pend_mode;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (busy) begin
                st_d.pend      = 1'b1;
                st_d.pend_mode = cfg_mode;
            end else begin
                st_d.mode = cfg_mode;
                st_d.pend = 1'b0;
            end
        end else if (st_q.pend && !busy) begin
            st_d.mode = st_q.pend_mode;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q <= '{mode: MODE_LEVEL, pend: 1'b0, pend_mode: MODE_LEVEL};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    // R10: a write while busy leaves the active mode untouched
    p_defer_busy_r10: assert property (@(posedge clk) disable iff (!pd_n)
        (cfg_we && busy) |=> (mode == $past(mode)));

    // R3: a write while ready takes effect at the next edge
    p_idle_write_r3: assert property (@(posedge clk) disable iff (!pd_n)
        (cfg_we && !busy) |=> (mode == $past(cfg_mode)));

endmodule

// File: rtl/flash_sts_pulse.sv
module flash_sts_pulse #(
    parameter int unsigned PULSE_LEN = 2
) (
    input  logic clk,
    input  logic pd_n,
    input  logic clr,
    input  logic evt,
    output logic active_nxt
);

    localparam int unsigned CW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pls_st_t;

    pls_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (evt) begin
            st_d.cnt = CW'(PULSE_LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_nxt = (st_d.cnt != '0);

    // R5 / R6: any enabled event (re)loads the full length
    p_load_full_r6: assert property (@(posedge clk) disable iff (!pd_n)
        (evt && !clr) |=> (st_q.cnt == CW'(PULSE_LEN)));

endmodule

// File: rtl/flash_sts_stat.sv
module flash_sts_stat
    import flash_sts_pkg::*;
(
    input  logic              clk,
    input  logic              pd_n,
    input  logic              busy,
    input  logic              ers_susp,
    input  logic              prg_susp,
    output logic [STAT_W-1:0] stat
);

    typedef struct packed {
        logic rdy;
        logic es;
        logic ps;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = !busy;
        if (ers_susp) begin
            st_d.es = 1'b1;
        end else if (busy) begin
            st_d.es = 1'b0;
        end
        if (prg_susp) begin
            st_d.ps = 1'b1;
        end else if (busy) begin
            st_d.ps = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q <= '{rdy: 1'b1, es: 1'b0, ps: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat               = '0;
        stat[STAT_RDY_BIT] = st_q.rdy;
        stat[STAT_ES_BIT]  = st_q.es;
        stat[STAT_PS_BIT]  = st_q.ps;
    end

    // R7: ready bit reflects the busy flag of the previous edge
    p_ready_bit_r7: assert property (@(posedge clk) disable iff (!pd_n)
        1'b1 |=> (stat[STAT_RDY_BIT] == !$past(busy)));

    // R8: erase-suspend flag holds while no resume is seen
    p_es_hold_r8: assert property (@(posedge clk) disable iff (!pd_n)
        (stat[STAT_ES_BIT] && !busy) |=> stat[STAT_ES_BIT]);

endmodule

// File: rtl/flash_sts_pin.sv
module flash_sts_pin
    import flash_sts_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 2
) (
    input  logic              clk,
    input  logic              pd_n,
    input  logic              wsm_busy,
    input  logic              done,
    input  logic [1:0]        done_kind,
    input  logic              ers_susp,
    input  logic              prg_susp,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    output logic              sts_pin,
    output logic [STAT_W-1:0] stat
);

    typedef struct packed {
        logic pin;
    } top_st_t;

    top_st_t   st_d, st_q;
    sts_mode_e mode;
    logic      is_level;
    logic      evt;
    logic      pls_active;

    flash_sts_cfg i_cfg (
        .clk      (clk),
        .pd_n     (pd_n),
        .busy     (wsm_busy),
        .cfg_we   (cfg_we),
        .cfg_mode (sts_mode_e'(cfg_mode)),
        .mode     (mode)
    );

    assign is_level = (mode == MODE_LEVEL);
    assign evt      = done && kind_enabled(mode, op_kind_e'(done_kind));

    flash_sts_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
        .clk        (clk),
        .pd_n       (pd_n),
        .clr        (is_level),
        .evt        (evt),
        .active_nxt (pls_active)
    );

    flash_sts_stat i_stat (
        .clk      (clk),
        .pd_n     (pd_n),
        .busy     (wsm_busy),
        .ers_susp (ers_susp),
        .prg_susp (prg_susp),
        .stat     (stat)
    );

    always_comb begin
        st_d = st_q;
        if (is_level) begin
            st_d.pin = !wsm_busy;
        end else begin
            st_d.pin = !pls_active;
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q <= '{pin: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_pin = st_q.pin;

    // R2: level mode follows busy with one register of delay
    p_level_track_r2: assert property (@(posedge clk) disable iff (!pd_n)
        (mode == MODE_LEVEL) |=> (sts_pin == !$past(wsm_busy)));

    // R4: a lock-bit completion never starts a pulse from an idle pin
    p_lock_quiet_r4: assert property (@(posedge clk) disable iff (!pd_n)
        (mode != MODE_LEVEL && sts_pin && done && done_kind == 2'b10 && !pls_active)
        |=> sts_pin);

    // R5: an enabled completion in a pulse mode pulls the pin low next
    p_pulse_low_r5: assert property (@(posedge clk) disable iff (!pd_n)
        (mode != MODE_LEVEL && evt) |=> !sts_pin);

endmodule

// File: tb/test_flash_sts_pin.sv
module test_flash_sts_pin;

    logic       clk = 1'b0;
    logic       pd_n;
    logic       wsm_busy, done, ers_susp, prg_susp, cfg_we;
    logic [1:0] done_kind, cfg_mode;
    logic       sts_pin;
    logic [7:0] stat;

    always #5 clk = ~clk;

    flash_sts_pin #(.PULSE_LEN(2)) i_flash_sts_pin (
        .clk       (clk),
        .pd_n      (pd_n),
        .wsm_busy  (wsm_busy),
        .done      (done),
        .done_kind (done_kind),
        .ers_susp  (ers_susp),
        .prg_susp  (prg_susp),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .sts_pin   (sts_pin),
        .stat      (stat)
    );

    typedef struct {
        logic       pin;
        logic [7:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    task automatic check(logic apin, logic [7:0] ast, logic epin, logic [7:0] est, string tag);
        n_cmp++;
        if (apin !== epin || ast !== est) begin
            n_bad++;
            $display("FAIL %s: pin=%b stat=%h expected pin=%b stat=%h", tag, apin, ast, epin, est);
        end
    endtask

    // monitor: pops one expectation per edge while the queue holds one
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(sts_pin, stat, e.pin, e.st, e.tag);
            end
        end
    end

    // driver: set inputs for one edge and queue the outputs expected after it
    task automatic cyc(logic b, logic d, logic [1:0] k, logic es, logic ps,
                       logic we, logic [1:0] m, logic epin, logic [7:0] est, string tag);
        exp_t e;
        @(negedge clk);
        wsm_busy = b; done = d; done_kind = k; ers_susp = es; prg_susp = ps;
        cfg_we = we; cfg_mode = m;
        e.pin = epin; e.st = est; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(logic b, logic epin, logic [7:0] est, string tag);
        cyc(b, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, epin, est, tag);
    endtask

    task automatic fin();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: run did not complete");
        fin();
    end

    initial begin
        pd_n = 1'b0;
        wsm_busy = 1'b1; done = 1'b0; done_kind = 2'b00;
        ers_susp = 1'b0; prg_susp = 1'b0; cfg_we = 1'b0; cfg_mode = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        check(sts_pin, stat, 1'b1, 8'h80, "R1 reset state");
        @(negedge clk);
        pd_n = 1'b1;
        wsm_busy = 1'b0;

        // level mode
        idle(1'b0, 1'b1, 8'h80, "R2 level ready");
        idle(1'b1, 1'b0, 8'h00, "R2 R7 level busy");
        idle(1'b1, 1'b0, 8'h00, "R2 level busy hold");
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'h80, "R4 no pulse in level");
        idle(1'b1, 1'b0, 8'h00, "R2 busy again");
        cyc(1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8'hC0, "R8 R2 erase suspend");
        idle(1'b0, 1'b1, 8'hC0, "R8 sticky");
        idle(1'b1, 1'b0, 8'h00, "R8 cleared on resume");
        cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 8'h84, "R9 program suspend");
        idle(1'b0, 1'b1, 8'h84, "R9 sticky");
        idle(1'b1, 1'b0, 8'h00, "R9 cleared on resume");
        idle(1'b0, 1'b1, 8'h80, "R7 ready");

        // erase-pulse mode
        cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 8'h80, "R3 write erase mode");
        idle(1'b1, 1'b1, 8'h00, "R11 pin ignores busy");
        cyc(1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'h80, "R4 program not enabled");
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h80, "R5 erase pulse start");
        idle(1'b0, 1'b0, 8'h80, "R5 pulse second cycle");
        idle(1'b0, 1'b1, 8'h80, "R5 pulse end");
        idle(1'b0, 1'b1, 8'h80, "R5 rests high");
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h80, "R6 first pulse");
        idle(1'b0, 1'b0, 8'h80, "R6 first pulse second");
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h80, "R6 retrigger");
        idle(1'b0, 1'b0, 8'h80, "R6 extended low");
        idle(1'b0, 1'b1, 8'h80, "R6 end");

        // deferred write to program mode
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 8'h00, "R10 write while busy");
        idle(1'b1, 1'b1, 8'h00, "R10 busy hold");
        cyc(1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h00, "R10 old mode still erase");
        idle(1'b1, 1'b0, 8'h00, "R10 pulse second");
        idle(1'b1, 1'b1, 8'h00, "R10 pulse end");
        idle(1'b0, 1'b1, 8'h80, "R10 ready applies");
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'h80, "R10 R4 erase now off");
        cyc(1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h80, "R4 program pulse");
        idle(1'b0, 1'b0, 8'h80, "R5 program second");
        idle(1'b0, 1'b1, 8'h80, "R5 program end");
        cyc(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'h80, "R4 lock-bit quiet");

        // both kinds
        cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 8'h80, "R3 write both mode");
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h80, "R3 both erase");
        idle(1'b0, 1'b0, 8'h80, "R3 both erase second");
        cyc(1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h80, "R3 R6 both program");
        idle(1'b0, 1'b0, 8'h80, "R6 both second");
        idle(1'b0, 1'b1, 8'h80, "R6 both end");

        // reset in mid-pulse
        cyc(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h80, "R1 pulse before reset");
        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        done = 1'b0;
        pd_n = 1'b0;
        #1;
        check(sts_pin, stat, 1'b1, 8'h80, "R1 reset aborts pulse");
        @(negedge clk);
        pd_n = 1'b1;
        idle(1'b1, 1'b0, 8'h00, "R1 level after reset");
        idle(1'b0, 1'b1, 8'h80, "R1 level ready after reset");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        fin();
    end

endmodule